// File: doc/BRIEF.md
# Streaming TLP Transmit Driver

This block sits on the application side of a transaction-layer link. It takes whole packets from a packet store and sends them over a 256-bit streaming transmit port. The store always shows the beat at its head. Alongside it the store gives the packet's length in doublewords and a flag that asks for the packet to be nullified. The driver works out how many beats the packet needs. It marks the first and last beats, encodes how many upper quadwords of the last beat carry no data, and sends odd byte parity with every beat. It pops the store once for each beat that crosses the port.

The port has a fixed ready latency. The driver keeps a short history of sampled ready values. It drives valid only in the cycle that lies exactly one latency after ready was seen high. When ready drops in mid-packet, valid follows it down within the latency. When ready returns, valid comes back within the same latency, and the packet continues from the first beat that was not yet accepted. After reset the driver waits a fixed number of cycles before it sends anything. A nullified packet has its error flag raised on its second beat, and the driver then leaves one idle cycle before the next packet begins.

Top module: `tlp_tx_driver`

## Requirements
- R1: tx_valid is high only in a cycle in which tx_ready was high READY_LAT cycles earlier (default 2). In every such cycle, when a beat is pending and no post-nullify gap applies, tx_valid is high.
- R2: If tx_ready drops in mid-packet, tx_valid falls within READY_LAT cycles. When tx_ready returns, transfer resumes within READY_LAT cycles, with the first beat not yet transferred. Beats are never repeated or skipped.
- R3: tx_valid is low while rst_n is low and for the first 2 cycles after rst_n rises.
- R4: A packet of L doublewords (1 to 1023) is sent as ceil(L/8) beats. tx_sop is high on the first beat only and tx_eop on the last beat only. Both are high on a one-beat packet.
- R5: On the end beat, tx_empty = 0 when L mod 8 is 0. Otherwise tx_empty = 4 - ceil((L mod 8)/2). The code counts unused quadwords taken from the top: 1 means bits 191:0 are valid, 2 means 127:0, 3 means 63:0.
- R6: On beats that are not end beats, tx_empty is 0.
- R7: For a packet of 3 or more beats with src_nullify set, tx_err is high on the second beat only. This beat is after the start beat and before the end beat.
- R8: src_nullify on a packet of 1 or 2 beats is ignored: tx_err stays low on every beat of that packet.
- R9: The cycle right after the end beat of a nullified packet has tx_valid low, even when ready permits a transfer.
- R10: tx_parity[i] is set so that tx_data[8i+7:8i] together with it has an odd number of ones.
- R11: tx_data equals src_data. src_take is high exactly in the cycles in which a beat is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_pkt_rdy | input | 1 | Store holds at least one packet |
| src_len_dw | input | 10 | Length in doublewords of the head packet |
| src_nullify | input | 1 | Head packet is to be nullified |
| src_data | input | 256 | Head beat of the store |
| src_take | output | 1 | Head beat consumed this cycle |
| tx_ready | input | 1 | Port ready, honoured READY_LAT cycles later |
| tx_valid | output | 1 | Beat transferred this cycle |
| tx_data | output | 256 | Beat data |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_empty | output | 2 | Unused upper quadwords on the last beat |
| tx_err | output | 1 | Nullify flag |
| tx_parity | output | 32 | Odd parity, one bit per data byte |

## Verification
The flow window and the post-nullify gap can land on the same cycle. A nullified packet can end just as a ready window opens, and then the driver must let that window pass unused. Pseudo-random ready patterns are run against a mix of nullified packets of one, two and three or more beats. This makes nullified end beats meet open windows often. Each cycle the bench predicts valid from its own ready history and its own gap flag, and compares it with tx_valid. A miss is reported against R9 when the gap was the cause and against R1 otherwise.

// File: rtl/tlp_tx_driver.sv
module tlp_tx_driver #(
  parameter int DATA_W     = 256,
  parameter int LEN_W      = 10,
  parameter int READY_LAT  = 2,
  parameter int START_WAIT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  src_pkt_rdy,
  input  logic [LEN_W-1:0]      src_len_dw,
  input  logic                  src_nullify,
  input  logic [DATA_W-1:0]     src_data,
  output logic                  src_take,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic [DATA_W-1:0]     tx_data,
  output logic                  tx_sop,
  output logic                  tx_eop,
  output logic [1:0]            tx_empty,
  output logic                  tx_err,
  output logic [DATA_W/8-1:0]   tx_parity
);
  localparam int DW_BEAT = DATA_W / 32;
  localparam int QW_BEAT = DATA_W / 64;
  localparam int BYTES   = DATA_W / 8;
  localparam int SH      = $clog2(DW_BEAT);
  localparam int BEAT_W  = LEN_W - SH + 1;
  localparam int WAIT_W  = $clog2(START_WAIT + 1);

  logic [READY_LAT-1:0] rdy_pipe;
  logic [WAIT_W-1:0]    wait_q;
  logic                 act_q, nul_q, gap_q;
  logic [BEAT_W-1:0]    idx_q, tot_q;
  logic [LEN_W-1:0]     len_q;

  logic [LEN_W-1:0]  len_cur;
  logic [LEN_W:0]    len_up;
  logic [BEAT_W-1:0] tot_cur, idx_cur;
  logic [SH-1:0]     rem;
  logic [SH:0]       qw_used;
  logic [1:0]        emp_calc;
  logic              nul_cur, nul_ok, allowed, started, last;

  assign len_cur  = act_q ? len_q : src_len_dw;
  assign nul_cur  = act_q ? nul_q : src_nullify;
  assign len_up   = {1'b0, len_cur} + (LEN_W+1)'(DW_BEAT - 1);
  assign tot_cur  = act_q ? tot_q : BEAT_W'(len_up >> SH);
  assign idx_cur  = act_q ? idx_q : '0;
  assign rem      = len_cur[SH-1:0];
  assign qw_used  = ({1'b0, rem} + (SH+1)'(1)) >> 1;
  assign emp_calc = (rem == '0) ? 2'd0 : 2'(QW_BEAT - int'(qw_used));

  assign allowed  = rdy_pipe[READY_LAT-1];
  assign started  = (wait_q == WAIT_W'(START_WAIT));
  assign last     = (idx_cur == tot_cur - BEAT_W'(1));
  assign nul_ok   = nul_cur && (tot_cur >= BEAT_W'(3));

  assign tx_valid = allowed && started && !gap_q && (act_q || src_pkt_rdy);
  assign tx_sop   = tx_valid && !act_q;
  assign tx_eop   = tx_valid && last;
  assign tx_err   = tx_valid && nul_ok && (idx_cur == BEAT_W'(1));
  assign tx_empty = tx_eop ? emp_calc : 2'd0;
  assign tx_data  = src_data;
  assign src_take = tx_valid;

  for (genvar i = 0; i < BYTES; i++) begin : g_par
    assign tx_parity[i] = ~^src_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_pipe <= '0;
      wait_q   <= '0;
      act_q    <= 1'b0;
      nul_q    <= 1'b0;
      gap_q    <= 1'b0;
      idx_q    <= '0;
      tot_q    <= '0;
      len_q    <= '0;
    end else begin
      rdy_pipe <= READY_LAT'({rdy_pipe, tx_ready});
      if (!started) wait_q <= wait_q + WAIT_W'(1);
      gap_q <= tx_valid && last && nul_ok;
      if (tx_valid) begin
        if (last) begin
          act_q <= 1'b0;
        end else begin
          act_q <= 1'b1;
          idx_q <= idx_cur + BEAT_W'(1);
          tot_q <= tot_cur;
          len_q <= len_cur;
          nul_q <= nul_cur;
        end
      end
    end
  end

  logic chk_in_pkt, chk_err_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_in_pkt   <= 1'b0;
      chk_err_seen <= 1'b0;
    end else if (tx_valid) begin
      chk_in_pkt   <= !tx_eop;
      chk_err_seen <= tx_eop ? 1'b0 : (chk_err_seen || tx_err);
    end
  end

  AST_VALID_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_ready, READY_LAT)); // R1
  AST_HOLD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(rst_n, 1) && $past(rst_n, 2))); // R3
  AST_SOP_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> !chk_in_pkt); // R4
  AST_ERR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (tx_valid && !tx_sop && !tx_eop)); // R7
  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> !chk_err_seen); // R7
  AST_GAP_AFTER_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_eop && chk_err_seen) |=> !tx_valid); // R9
endmodule

// File: tb/sim_tlp_tx_driver.sv
module sim_tlp_tx_driver;
  localparam int NP = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic src_pkt_rdy, src_nullify, src_take, tx_ready;
  logic [9:0] src_len_dw;
  logic [255:0] src_data, tx_data;
  logic tx_valid, tx_sop, tx_eop, tx_err;
  logic [1:0] tx_empty;
  logic [31:0] tx_parity;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlp_tx_driver u0 (
    .clk(clk), .rst_n(rst_n), .src_pkt_rdy(src_pkt_rdy), .src_len_dw(src_len_dw),
    .src_nullify(src_nullify), .src_data(src_data), .src_take(src_take),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_empty(tx_empty), .tx_err(tx_err), .tx_parity(tx_parity));

  function automatic int plen(int p);
    return (p < 24) ? p + 1 : ((p * 37) % 250) + 1;
  endfunction
  function automatic bit pnul(int p);
    return (p % 3) == 1;
  endfunction
  function automatic logic [255:0] bdata(int p, int b);
    logic [255:0] d;
    for (int k = 0; k < 8; k++)
      d[32*k +: 32] = {8'(p), 8'(b), 8'(p * 3 + b + k), 8'hA5 ^ 8'(b * 7 + k)};
    return d;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int pidx = 0, bidx = 0, cyc = 0;
  bit gap_b = 0;
  logic [2:0] h;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    int beats, len, rm;
    bit took, rdy, expv, nulok;
    logic [1:0] exp_emp;
    logic [31:0] exp_par;
    rst_n = 1'b0; tx_ready = 1'b1;
    src_pkt_rdy = 1'b1; src_len_dw = 10'(plen(0)); src_nullify = pnul(0); src_data = bdata(0, 0);
    repeat (4) begin
      @(negedge clk);
      check(!tx_valid && !src_take, "R3 reset", 256'(tx_valid), 0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1; h = '0;
    while (pidx < NP && cyc < 5000) begin
      if (cyc < 40) rdy = 1'b1;
      else if (cyc < 600) rdy = lfsr[0] | lfsr[3];
      else rdy = (cyc % 5) != 0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = rdy;
      h = {h[1:0], rdy};
      len = plen(pidx);
      beats = (len + 7) / 8;
      src_pkt_rdy = 1'b1; src_len_dw = 10'(len); src_nullify = pnul(pidx);
      src_data = bdata(pidx, bidx);
      @(negedge clk);
      expv = (cyc >= 2) && h[2] && !gap_b;
      if (cyc < 2) check(!tx_valid, "R3 startup wait", 256'(tx_valid), 0);
      else if (gap_b) check(tx_valid == expv, "R9 idle after nullify", 256'(tx_valid), 256'(expv));
      else check(tx_valid == expv, "R1/R2 ready window", 256'(tx_valid), 256'(expv));
      check(src_take == tx_valid, "R11 take", 256'(src_take), 256'(tx_valid));
      if (tx_valid) begin
        nulok = pnul(pidx) && beats >= 3;
        rm = len % 8;
        exp_emp = (rm == 0) ? 2'd0 : 2'(4 - (rm + 1) / 2);
        for (int k = 0; k < 32; k++) exp_par[k] = ~^tx_data[8*k +: 8];
        check(tx_data == bdata(pidx, bidx), "R2/R11 beat order", tx_data, bdata(pidx, bidx));
        check(tx_sop == (bidx == 0), "R4 sop", 256'(tx_sop), 256'(bidx == 0));
        check(tx_eop == (bidx == beats - 1), "R4 eop", 256'(tx_eop), 256'(bidx == beats - 1));
        if (bidx == beats - 1) check(tx_empty == exp_emp, "R5 empty", 256'(tx_empty), 256'(exp_emp));
        else check(tx_empty == 2'd0, "R6 empty mid", 256'(tx_empty), 0);
        if (pnul(pidx) && beats < 3) check(!tx_err, "R8 short nullify ignored", 256'(tx_err), 0);
        else check(tx_err == (nulok && bidx == 1), "R7 nullify", 256'(tx_err), 256'(nulok && bidx == 1));
        check(tx_parity == exp_par, "R10 parity", 256'(tx_parity), 256'(exp_par));
      end
      took = tx_valid;
      @(posedge clk); #1;
      gap_b = 0;
      if (took) begin
        if (bidx == beats - 1) begin
          gap_b = pnul(pidx) && beats >= 3;
          pidx++; bidx = 0;
        end else bidx++;
      end
      cyc++;
    end
    check(pidx == NP, "R1 all packets sent", 256'(pidx), 256'(NP));
    src_pkt_rdy = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(!tx_valid, "R1 idle when store empty", 256'(tx_valid), 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule